// File: doc/BRIEF.md
# Multi-Symbol TMDS/TERC4 Lane Encoder

This block encodes one serial lane of a digital display link. Each clock it takes a group of one, two or four input symbols and returns the same number of 10-bit line symbols, packed into one word for a transceiver's parallel input. A two-bit period select picks the coding for the whole group. Video bytes go through the transition-minimising, DC-balancing 8b/10b code. Auxiliary nibbles go through the fixed 4b/10b TERC4 table. Two-bit control values map to four fixed tokens. One instance serves one lane; a link uses one instance per lane.

The video code tracks a running disparity. Inside one clock the disparity passes from symbol 0 up to the highest symbol. The value left after the last symbol is held in a register for the next clock. When the mode input is low the lane runs as plain DVI: auxiliary coding is never produced, and an auxiliary request is sent as a control period.

Top module: `tmds_lane_encoder`

## Requirements
- R1: While `rst_n` is low, `sym_out` is all zeros and the running disparity is zero, so the first video group after reset is coded from zero disparity.
- R2: Every input group shows on `sym_out` exactly one clock later, whatever the value of `SYM_PER_CLK`. Symbol k uses input slices `vid_data[8k+7:8k]`, `aux_data[4k+3:4k]` and `ctl_data[2k+1:2k]`, and appears at `sym_out[10k+9:10k]`.
- R3: With `period_sel`=1 (video), each byte is coded with the standard TMDS rules. The stage-1 word uses XNOR chaining when the byte has more than four ones, or exactly four ones with bit 0 clear; otherwise it uses XOR chaining. Bit 8 of the stage-1 word is 1 for XOR. Stage 2 then decides inversion of bits 7:0 and sets bit 9 from the running disparity and the stage-1 balance, and the disparity is updated by the standard amounts.
- R4: The disparity used by symbol k+1 is the one left by symbol k in the same clock. The disparity left by the top symbol is used by symbol 0 of the next clock.
- R5: With `period_sel`=0, or the reserved value 3, each symbol is a control token chosen by its `ctl_data` pair {C1,C0}: 00 gives 0x354, 01 gives 0x0AB, 10 gives 0x154 and 11 gives 0x2AB. The running disparity becomes zero.
- R6: With `period_sel`=2 and `hdmi_mode`=1, each nibble 0..15 maps to 0x29C, 0x263, 0x2E4, 0x2E2, 0x171, 0x11E, 0x18E, 0x13C, 0x2CC, 0x139, 0x19C, 0x2C6, 0x28E, 0x271, 0x163, 0x2C3, in that order.
- R7: An auxiliary group in HDMI mode leaves the running disparity unchanged. The next video group codes as if the auxiliary group had not occurred.
- R8: With `hdmi_mode`=0, `period_sel`=2 acts as a control period. The tokens come from `ctl_data` as in R5, `aux_data` has no effect, and the disparity becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdmi_mode | input | 1 | 1: HDMI (auxiliary coding allowed); 0: DVI |
| period_sel | input | 2 | 0 control, 1 video, 2 auxiliary, 3 treated as control |
| vid_data | input | 8*SYM_PER_CLK | Video bytes, symbol 0 in the low byte |
| aux_data | input | 4*SYM_PER_CLK | Auxiliary nibbles, symbol 0 in the low nibble |
| ctl_data | input | 2*SYM_PER_CLK | Control pairs {C1,C0}, symbol 0 in the low pair |
| sym_out | output | 10*SYM_PER_CLK | Registered 10-bit symbols, symbol 0 in the low bits |

## Verification
The assertions assume that `period_sel` and `hdmi_mode` are known values on every clock edge after reset. They also assume that one select applies to a whole group. The disparity checks compare the register against the select presented in the cycle before. The bench drives only the four select codes and both mode values, and it changes inputs only just after the falling edge. Every group is therefore a single legal period, and it is stable when it is sampled.

// File: rtl/tmds_enc_pkg.sv
package tmds_enc_pkg;

    localparam int SYM_W  = 10;
    localparam int DISP_W = 6;

    typedef logic signed [DISP_W-1:0] disp_t;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_VIDEO = 2'd1,
        SEL_AUX   = 2'd2,
        SEL_RSVD  = 2'd3
    } period_e;

    // Control tokens indexed by {C1,C0}
    function automatic logic [SYM_W-1:0] ctrl_token(input logic [1:0] c);
        case (c)
            2'b00:   return 10'h354;
            2'b01:   return 10'h0AB;
            2'b10:   return 10'h154;
            default: return 10'h2AB;
        endcase
    endfunction

    // TERC4 codewords indexed by nibble
    function automatic logic [SYM_W-1:0] terc4_code(input logic [3:0] n);
        case (n)
            4'h0:    return 10'h29C;
            4'h1:    return 10'h263;
            4'h2:    return 10'h2E4;
            4'h3:    return 10'h2E2;
            4'h4:    return 10'h171;
            4'h5:    return 10'h11E;
            4'h6:    return 10'h18E;
            4'h7:    return 10'h13C;
            4'h8:    return 10'h2CC;
            4'h9:    return 10'h139;
            4'hA:    return 10'h19C;
            4'hB:    return 10'h2C6;
            4'hC:    return 10'h28E;
            4'hD:    return 10'h271;
            4'hE:    return 10'h163;
            default: return 10'h2C3;
        endcase
    endfunction

endpackage

// File: rtl/tmds_video_sym.sv
module tmds_video_sym
    import tmds_enc_pkg::*;
(
    input  logic [7:0]       byte_i,
    input  disp_t            disp_i,
    output logic [SYM_W-1:0] sym_o,
    output disp_t            disp_o
);
    logic [8:0] stage1;
    logic       use_xnor;
    int         ones_in;
    int         ones_s1;
    disp_t      bal;

    always_comb begin
        ones_in = 0;
        for (int i = 0; i < 8; i++) ones_in = ones_in + int'(byte_i[i]);
        use_xnor = (ones_in > 4) || ((ones_in == 4) && !byte_i[0]);

        stage1[0] = byte_i[0];
        for (int i = 1; i < 8; i++)
            stage1[i] = use_xnor ? ~(stage1[i-1] ^ byte_i[i]) : (stage1[i-1] ^ byte_i[i]);
        stage1[8] = ~use_xnor;

        ones_s1 = 0;
        for (int i = 0; i < 8; i++) ones_s1 = ones_s1 + int'(stage1[i]);
        bal = disp_t'(2 * ones_s1 - 8);

        if (disp_i == '0 || bal == '0) begin
            sym_o  = {~stage1[8], stage1[8], stage1[8] ? stage1[7:0] : ~stage1[7:0]};
            disp_o = stage1[8] ? (disp_i + bal) : (disp_i - bal);
        end else if ((disp_i > 0 && bal > 0) || (disp_i < 0 && bal < 0)) begin
            sym_o  = {1'b1, stage1[8], ~stage1[7:0]};
            disp_o = disp_i - bal + (stage1[8] ? disp_t'(2) : disp_t'(0));
        end else begin
            sym_o  = {1'b0, stage1[8], stage1[7:0]};
            disp_o = disp_i + bal - (stage1[8] ? disp_t'(0) : disp_t'(2));
        end
    end
endmodule

// File: rtl/tmds_lane_slot.sv
module tmds_lane_slot
    import tmds_enc_pkg::*;
(
    input  period_e          sel_i,
    input  logic             hdmi_i,
    input  logic [7:0]       vid_i,
    input  logic [3:0]       aux_i,
    input  logic [1:0]       ctl_i,
    input  disp_t            disp_i,
    output logic [SYM_W-1:0] sym_o,
    output disp_t            disp_o
);
    logic [SYM_W-1:0] vid_sym;
    disp_t            vid_disp;

    tmds_video_sym u_vid (
        .byte_i (vid_i),
        .disp_i (disp_i),
        .sym_o  (vid_sym),
        .disp_o (vid_disp)
    );

    always_comb begin
        if (sel_i == SEL_VIDEO) begin
            sym_o  = vid_sym;
            disp_o = vid_disp;
        end else if (sel_i == SEL_AUX && hdmi_i) begin
            sym_o  = terc4_code(aux_i);
            disp_o = disp_i;
        end else begin
            sym_o  = ctrl_token(ctl_i);
            disp_o = '0;
        end
    end
endmodule

// File: rtl/tmds_lane_encoder.sv
module tmds_lane_encoder
    import tmds_enc_pkg::*;
#(
    parameter int SYM_PER_CLK = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hdmi_mode,
    input  logic [1:0]                   period_sel,
    input  logic [8*SYM_PER_CLK-1:0]     vid_data,
    input  logic [4*SYM_PER_CLK-1:0]     aux_data,
    input  logic [2*SYM_PER_CLK-1:0]     ctl_data,
    output logic [SYM_W*SYM_PER_CLK-1:0] sym_out
);
    localparam int WORD_W = SYM_W * SYM_PER_CLK;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        disp_t             disp;
    } state_t;

    state_t  st_d, st_q;
    period_e sel;
    disp_t   chain [SYM_PER_CLK+1];
    logic [SYM_W-1:0] slot_sym [SYM_PER_CLK];

    assign sel      = period_e'(period_sel);
    assign chain[0] = st_q.disp;

    for (genvar k = 0; k < SYM_PER_CLK; k++) begin : g_slot
        tmds_lane_slot u_slot (
            .sel_i  (sel),
            .hdmi_i (hdmi_mode),
            .vid_i  (vid_data[8*k +: 8]),
            .aux_i  (aux_data[4*k +: 4]),
            .ctl_i  (ctl_data[2*k +: 2]),
            .disp_i (chain[k]),
            .sym_o  (slot_sym[k]),
            .disp_o (chain[k+1])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < SYM_PER_CLK; k++)
            st_d.word[SYM_W*k +: SYM_W] = slot_sym[k];
        st_d.disp = chain[SYM_PER_CLK];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sym_out = st_q.word;

    // R5
    ctrl_disp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_sel == 2'd0 || period_sel == 2'd3) |=> (st_q.disp == '0));

    // R7
    aux_disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdmi_mode && period_sel == 2'd2) |=> $stable(st_q.disp));

    // R8
    dvi_aux_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdmi_mode && period_sel == 2'd2) |=> (st_q.disp == '0));

    // R3
    disp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.disp >= disp_t'(-16)) && (st_q.disp <= disp_t'(16)));

endmodule

// File: tb/tmds_lane_encoder_test.sv
module tmds_lane_encoder_test;
    localparam int N = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hdmi_mode = 1'b1;
    logic [1:0]      period_sel = 2'd0;
    logic [8*N-1:0]  vid_data = '0;
    logic [4*N-1:0]  aux_data = '0;
    logic [2*N-1:0]  ctl_data = '0;
    logic [10*N-1:0] sym_out;

    int checks = 0;
    int fails  = 0;
    int rd     = 0;
    bit done   = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    tmds_lane_encoder #(.SYM_PER_CLK(N)) uut (
        .clk(clk), .rst_n(rst_n), .hdmi_mode(hdmi_mode), .period_sel(period_sel),
        .vid_data(vid_data), .aux_data(aux_data), .ctl_data(ctl_data), .sym_out(sym_out)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] nxt();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [9:0] tok(input logic [1:0] c);
        logic [9:0] t [4] = '{10'h354, 10'h0AB, 10'h154, 10'h2AB};
        return t[c];
    endfunction

    function automatic logic [9:0] terc(input logic [3:0] n);
        logic [9:0] t [16] = '{10'h29C, 10'h263, 10'h2E4, 10'h2E2, 10'h171, 10'h11E,
                               10'h18E, 10'h13C, 10'h2CC, 10'h139, 10'h19C, 10'h2C6,
                               10'h28E, 10'h271, 10'h163, 10'h2C3};
        return t[n];
    endfunction

    function automatic logic [9:0] ref_video(input logic [7:0] b, inout int d);
        int k, h, z;
        bit inv;
        logic [8:0] m;
        logic [9:0] r;
        k = $countones(b);
        inv = (k > 4) || (k == 4 && b[0] == 1'b0);
        m[0] = b[0];
        for (int j = 1; j < 8; j++) m[j] = m[j-1] ^ b[j] ^ inv;
        m[8] = !inv;
        h = $countones(m[7:0]);
        z = 8 - h;
        if (d == 0 || h == z) begin
            r = {~m[8], m[8], m[8] ? m[7:0] : ~m[7:0]};
            d = d + (m[8] ? (h - z) : (z - h));
        end else if ((d > 0 && h > z) || (d < 0 && z > h)) begin
            r = {1'b1, m[8], ~m[7:0]};
            d = d + 2 * int'(m[8]) + z - h;
        end else begin
            r = {1'b0, m[8], m[7:0]};
            d = d - 2 * (1 - int'(m[8])) + h - z;
        end
        return r;
    endfunction

    task automatic apply(input bit md, input logic [1:0] sel, input logic [8*N-1:0] v,
                         input logic [4*N-1:0] a, input logic [2*N-1:0] c, input string tag);
        logic [10*N-1:0] exp_w;
        hdmi_mode = md; period_sel = sel; vid_data = v; aux_data = a; ctl_data = c;
        for (int k = 0; k < N; k++) begin
            if (sel == 2'd1) exp_w[10*k +: 10] = ref_video(v[8*k +: 8], rd);
            else if (sel == 2'd2 && md) exp_w[10*k +: 10] = terc(a[4*k +: 4]);
            else begin
                exp_w[10*k +: 10] = tok(c[2*k +: 2]);
                rd = 0;
            end
        end
        @(negedge clk);
        checks++;
        if (sym_out !== exp_w) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, sym_out, exp_w);
        end
    endtask

    function automatic logic [8*N-1:0] rnd_vid();
        logic [8*N-1:0] r;
        for (int k = 0; k < N; k++) r[8*k +: 8] = nxt()[15:8];
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (sym_out !== '0) begin
            fails++;
            $display("FAIL R1 reset: actual=%h expected=0", sym_out);
        end
        rst_n = 1'b1;
        rd = 0;
        // R1: first video group after reset starts from zero disparity
        apply(1'b1, 2'd1, 32'hFF00_F00F, '0, '0, "R1 first video");

        // R3 R4 R2: byte sweep, several patterns per lane
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            b = 8'(i);
            apply(1'b1, 2'd1, {~b, 8'(b + 8'd37), b ^ 8'hA5, b}, '0, '0, "R3 R4 video sweep");
        end
        for (int i = 0; i < 300; i++)
            apply(1'b1, 2'd1, rnd_vid(), '0, '0, "R4 video chain");

        // R5: every control combination, select 0 and reserved 3, then video
        for (int i = 0; i < 256; i++) begin
            apply(1'b1, 2'd1, rnd_vid(), '0, '0, "R4 video before ctrl");
            apply(1'b1, (i % 2 == 0) ? 2'd0 : 2'd3, '0, 16'(nxt()), 8'(i), "R5 control");
            apply(1'b1, 2'd1, rnd_vid(), '0, '0, "R5 video after ctrl");
        end

        // R6 R7: all nibbles, disparity held across aux
        for (int i = 0; i < 64; i++) begin
            logic [3:0] n;
            n = 4'(i);
            apply(1'b1, 2'd1, rnd_vid(), '0, '0, "R7 video before aux");
            apply(1'b1, 2'd2, '0, {4'(n + 4'd3), 4'(n + 4'd7), ~n, n}, 8'(nxt()), "R6 terc4");
            apply(1'b1, 2'd1, rnd_vid(), '0, '0, "R7 video after aux");
        end

        // R8: DVI mode, aux select gives control tokens
        for (int i = 0; i < 64; i++) begin
            apply(1'b0, 2'd1, rnd_vid(), '0, '0, "R8 dvi video");
            apply(1'b0, 2'd2, '0, 16'(nxt()), 8'(i * 3), "R8 dvi aux as ctrl");
            apply(1'b0, 2'd1, rnd_vid(), '0, '0, "R8 dvi video after");
        end

        // R2 R3-R8 mixed traffic
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            r = nxt();
            apply(r[20], r[17:16], rnd_vid(), 16'(nxt()), 8'(nxt()), "R2 mixed");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule